// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable part of a frequency synthesizer's feedback path. It runs on the output clock of an external dual-modulus prescaler. That prescaler divides the oscillator signal by P when the modulus line is low and by P+1 when it is high. The block holds two down-counters: a main count B and a swallow count A. For the first A prescaler periods of every output cycle it asks for the larger modulus, and for the remaining B−A periods it asks for the smaller one. The oscillator is therefore divided by P·B + A in total, and one feedback pulse per output cycle goes to the phase detector.

The count values and the prescaler-pair select come from configuration latches. They are sampled only at a cycle boundary, so a reprogrammed ratio never produces a truncated or stretched cycle. The divider stops when either of two inputs is high: a powerdown input or a counter-clear input. While stopped it keeps reloading from its inputs. When the hold is released, a fresh cycle starts on the first prescaler edge that sees the hold low, which keeps the restart aligned to the reference side within one prescaler period. A parameter limits how many swallow bits are honoured, so one design serves both a 7-bit and a 4-bit swallow instance.

Top module: `pulse_swallow_div`

## Requirements
- R1: While rst_n is low, mod_plus1, fb_pulse and psc_wide are all 0.
- R2: With both hold inputs low, fb_pulse is high for exactly one prescaler period per B periods, and that period is the last one of the cycle (period index B−1, counting from 0).
- R3: mod_plus1 is high during periods 0 to A−1 of each cycle and low during periods A to B−1. With A=0 it never rises, and with A=B it stays high for the whole cycle.
- R4: With a prescaler that divides by P+1 while mod_plus1 is high and by P otherwise, one output cycle spans P·B+A input cycles. This holds for P=32/64 on the 7-bit instance and for P=8/16 on the 4-bit instance.
- R5: A change on b_val or a_val in the middle of a cycle leaves the rest of that cycle unchanged. The new values govern the next cycle.
- R6: size_sel is copied to psc_wide only at a cycle boundary or while the divider is held. psc_wide stays stable for the whole cycle that it governs.
- R7: In every prescaler period that follows an edge at which pwr_down was high, mod_plus1 and fb_pulse are 0. After release, the period that follows the first edge with pwr_down low is period 0 of a cycle that uses the values present at that edge.
- R8: cnt_clear has the same hold effect as pwr_down. A cycle interrupted by it is discarded and does not resume.
- R9: Swallow bits at or above position A_USED are ignored. With A_USED=4, a_val=0x23 behaves as A=3.
- R10: The legal range is B from 3 to 2047 with A ≤ B. At B=3, at B=2047 and at A=127=B, the patterns of R2 and R3 hold exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_psc | input | 1 | Prescaler output clock; one rising edge per prescaler period |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Powerdown: stops and holds the divider |
| cnt_clear | input | 1 | Counter clear: stops and holds the divider |
| b_val | input | B_W | Latched main count B |
| a_val | input | A_W | Latched swallow count A |
| size_sel | input | 1 | Prescaler pair select (0 lower pair, 1 upper pair) |
| mod_plus1 | output | 1 | High requests divide by P+1 from the prescaler |
| psc_wide | output | 1 | Pair select applied to the prescaler for the current cycle |
| fb_pulse | output | 1 | One-period feedback pulse to the phase detector |

## Verification
The bench targets the edge patterns of the swallow count: A=0, A=B, and a large A against the smallest and largest B. A design with an off-by-one in the swallow compare would show one modulus period too many or too few, and the summed input-cycle count would miss P·B+A. Reprogramming of the counts and of the pair select is done in mid-cycle, which catches a design that reloads early and produces a short or mixed cycle. Powerdown and clear are applied in mid-cycle with new values behind them, which exposes a divider that resumes the old count or needs an extra period to realign. A second instance with a narrow swallow field checks that high swallow bits are not treated as part of the count.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
  typedef enum logic {
    PSD_ARM = 1'b0,
    PSD_RUN = 1'b1
  } psd_state_e;

  localparam int unsigned PSD_B_W_DEF = 11;
  localparam int unsigned PSD_A_W_DEF = 7;
endpackage

// File: rtl/psd_rst_sync.sv
`timescale 1ns/1ps
module psd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/psd_main_cnt.sv
`timescale 1ns/1ps
module psd_main_cnt #(
  parameter int unsigned B_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [B_W-1:0] load_val,
  output logic           term
);
  logic [B_W-1:0] left_q, left_d;
  logic           cnt_en;

  always_comb begin
    left_d = left_q;
    if (load)      left_d = load_val;
    else if (step) left_d = left_q - B_W'(1);
  end

  assign cnt_en = load | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left_q <= '0;
    else if (cnt_en) left_q <= left_d;
  end

  assign term = (left_q == B_W'(1));
endmodule

// File: rtl/psd_swallow_cnt.sv
`timescale 1ns/1ps
module psd_swallow_cnt #(
  parameter int unsigned A_W    = 7,
  parameter int unsigned A_USED = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [A_W-1:0] load_val,
  output logic           active
);
  logic [A_W-1:0] a_eff;
  logic [A_W-1:0] left_q, left_d;
  logic           cnt_en;

  generate
    if (A_USED < A_W) begin : g_mask
      assign a_eff = {{(A_W-A_USED){1'b0}}, load_val[A_USED-1:0]};
    end else begin : g_full
      assign a_eff = load_val;
    end
  endgenerate

  always_comb begin
    left_d = left_q;
    if (load)                         left_d = a_eff;
    else if (step && (left_q != '0))  left_d = left_q - A_W'(1);
  end

  assign cnt_en = load | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left_q <= '0;
    else if (cnt_en) left_q <= left_d;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/psd_ctrl.sv
`timescale 1ns/1ps
module psd_ctrl
  import psd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic term,
  output logic load,
  output logic step,
  output logic run
);
  psd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    case (state_q)
      PSD_ARM: begin
        load = 1'b1;
        if (!hold) state_d = PSD_RUN;
      end
      PSD_RUN: begin
        if (hold) begin
          load    = 1'b1;
          state_d = PSD_ARM;
        end else if (term) begin
          load = 1'b1;
        end else begin
          step = 1'b1;
        end
      end
      default: state_d = PSD_ARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PSD_ARM;
    else        state_q <= state_d;
  end

  assign run = (state_q == PSD_RUN);
endmodule

// File: rtl/pulse_swallow_div.sv
`timescale 1ns/1ps
module pulse_swallow_div
  import psd_pkg::*;
#(
  parameter int unsigned B_W    = PSD_B_W_DEF,
  parameter int unsigned A_W    = PSD_A_W_DEF,
  parameter int unsigned A_USED = PSD_A_W_DEF
) (
  input  logic           clk_psc,
  input  logic           rst_n,
  input  logic           pwr_down,
  input  logic           cnt_clear,
  input  logic [B_W-1:0] b_val,
  input  logic [A_W-1:0] a_val,
  input  logic           size_sel,
  output logic           mod_plus1,
  output logic           psc_wide,
  output logic           fb_pulse
);
  logic rst_n_s;
  logic hold;
  logic load, step, run;
  logic term, a_active;
  logic wide_q;

  psd_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk_psc),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  assign hold = pwr_down | cnt_clear;

  psd_ctrl u_ctrl (
    .clk   (clk_psc),
    .rst_n (rst_n_s),
    .hold  (hold),
    .term  (term),
    .load  (load),
    .step  (step),
    .run   (run)
  );

  psd_main_cnt #(.B_W(B_W)) u_main (
    .clk      (clk_psc),
    .rst_n    (rst_n_s),
    .load     (load),
    .step     (step),
    .load_val (b_val),
    .term     (term)
  );

  psd_swallow_cnt #(.A_W(A_W), .A_USED(A_USED)) u_swal (
    .clk      (clk_psc),
    .rst_n    (rst_n_s),
    .load     (load),
    .step     (step),
    .load_val (a_val),
    .active   (a_active)
  );

  always_ff @(posedge clk_psc or negedge rst_n_s) begin
    if (!rst_n_s)  wide_q <= 1'b0;
    else if (load) wide_q <= size_sel;
  end

  assign mod_plus1 = run & a_active;
  assign fb_pulse  = run & term;
  assign psc_wide  = wide_q;
endmodule

// File: rtl/psd_chk.sv
`timescale 1ns/1ps
module psd_chk #(
  parameter int unsigned B_W    = 11,
  parameter int unsigned A_W    = 7,
  parameter int unsigned A_USED = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pwr_down,
  input logic           cnt_clear,
  input logic [B_W-1:0] b_val,
  input logic [A_W-1:0] a_val,
  input logic           mod_plus1,
  input logic           fb_pulse,
  input logic           psc_wide,
  input logic           run
);
  logic [A_W-1:0] a_chk;
  logic           hold_c;

  always_comb begin
    a_chk = a_val;
    for (int i = 0; i < int'(A_W); i++) begin
      if (i >= int'(A_USED)) a_chk[i] = 1'b0;
    end
  end

  assign hold_c = pwr_down | cnt_clear;

  AST_FB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && (b_val >= B_W'(3))) |=> !fb_pulse);  // R2

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_c |=> (!fb_pulse && !mod_plus1));  // R7

  AST_MOD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && !hold_c && (a_chk != '0)) |=> mod_plus1);  // R3

  AST_MOD_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mod_plus1 && !fb_pulse) |=> !mod_plus1);  // R3

  AST_WIDE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fb_pulse && !hold_c) |=> $stable(psc_wide));  // R6
endmodule

bind pulse_swallow_div psd_chk #(.B_W(B_W), .A_W(A_W), .A_USED(A_USED)) u_chk (
  .clk       (clk_psc),
  .rst_n     (rst_n),
  .pwr_down  (pwr_down),
  .cnt_clear (cnt_clear),
  .b_val     (b_val),
  .a_val     (a_val),
  .mod_plus1 (mod_plus1),
  .fb_pulse  (fb_pulse),
  .psc_wide  (psc_wide),
  .run       (run)
);

// File: tb/pulse_swallow_div_tb_top.sv
`timescale 1ns/1ps
module pulse_swallow_div_tb_top;
  logic        clk;
  logic        rst_n;
  logic        pwr_down;
  logic        cnt_clear;
  logic [10:0] b_val;
  logic [6:0]  a_val;
  logic        size_sel;
  logic        mod_rf, wide_rf, fb_rf;
  logic        mod_if, wide_if, fb_if;

  int n_chk;
  int n_err;
  bit done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  pulse_swallow_div #(.B_W(11), .A_W(7), .A_USED(7)) dut_i (
    .clk_psc (clk), .rst_n (rst_n), .pwr_down (pwr_down), .cnt_clear (cnt_clear),
    .b_val (b_val), .a_val (a_val), .size_sel (size_sel),
    .mod_plus1 (mod_rf), .psc_wide (wide_rf), .fb_pulse (fb_rf)
  );

  pulse_swallow_div #(.B_W(11), .A_W(7), .A_USED(4)) dut_if_i (
    .clk_psc (clk), .rst_n (rst_n), .pwr_down (pwr_down), .cnt_clear (cnt_clear),
    .b_val (b_val), .a_val (a_val), .size_sel (size_sel),
    .mod_plus1 (mod_if), .psc_wide (wide_if), .fb_pulse (fb_if)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // One prescaler period k of a cycle with counts B/A; IF copy sees A mod 16
  task automatic check_period(input int bb, input int aa, input int k, input string tag);
    chk({tag, " mod rf"}, int'(mod_rf), int'(k < aa));
    chk({tag, " mod if"}, int'(mod_if), int'(k < (aa & 15)));
    chk({tag, " fb rf"},  int'(fb_rf),  int'(k == bb - 1));
    chk({tag, " fb if"},  int'(fb_if),  int'(k == bb - 1));
  endtask

  task automatic run_cycles(input int bb, input int aa, input int ncyc, input string tag);
    for (int c = 0; c < ncyc; c++) begin
      for (int k = 0; k < bb; k++) begin
        check_period(bb, aa, k, tag);
        tick();
      end
    end
  endtask

  task automatic arm(input int bb, input int aa, input bit wide);
    cnt_clear = 1'b1;
    tick();
    b_val     = 11'(bb);
    a_val     = 7'(aa);
    size_sel  = wide;
    cnt_clear = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwr_down = 1'b0; cnt_clear = 1'b0;
    b_val = 11'd5; a_val = 7'd2; size_sel = 1'b1;
    tick(); tick();
    chk("R1 mod rf", int'(mod_rf), 0);
    chk("R1 fb rf", int'(fb_rf), 0);
    chk("R1 wide rf", int'(wide_rf), 0);
    chk("R1 mod if", int'(mod_if), 0);
    chk("R1 wide if", int'(wide_if), 0);
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic t_basic();
    arm(5, 2, 1'b0);
    run_cycles(5, 2, 3, "R2 R3 basic");
  endtask

  task automatic t_ratio(input bit wide);
    int sum_rf, sum_if, p_rf, p_if;
    arm(9, 4, wide);
    p_rf = wide ? 64 : 32;
    p_if = wide ? 16 : 8;
    chk("R6 wide rf", int'(wide_rf), int'(wide));
    chk("R6 wide if", int'(wide_if), int'(wide));
    sum_rf = 0; sum_if = 0;
    for (int k = 0; k < 9; k++) begin
      sum_rf += mod_rf ? p_rf + 1 : p_rf;
      sum_if += mod_if ? p_if + 1 : p_if;
      tick();
    end
    chk("R4 ratio rf", sum_rf, p_rf * 9 + 4);
    chk("R4 ratio if", sum_if, p_if * 9 + 4);
  endtask

  task automatic t_bounds();
    arm(3, 0, 1'b0);     run_cycles(3, 0, 2, "R10 R3 B3 A0");
    arm(3, 3, 1'b0);     run_cycles(3, 3, 2, "R10 R3 B3 A3");
    arm(127, 127, 1'b1); run_cycles(127, 127, 1, "R10 A127 B127");
    arm(2047, 127, 1'b0); run_cycles(2047, 127, 1, "R10 B2047");
  endtask

  task automatic t_midchange();
    arm(6, 1, 1'b0);
    check_period(6, 1, 0, "R5 old"); tick();
    check_period(6, 1, 1, "R5 old");
    b_val = 11'd4; a_val = 7'd3;
    tick();
    for (int k = 2; k < 6; k++) begin
      check_period(6, 1, k, "R5 old tail");
      tick();
    end
    run_cycles(4, 3, 2, "R5 new");
  endtask

  task automatic t_size();
    arm(5, 2, 1'b0);
    tick();
    size_sel = 1'b1;
    for (int k = 1; k < 5; k++) begin
      chk("R6 wide held rf", int'(wide_rf), 0);
      chk("R6 wide held if", int'(wide_if), 0);
      tick();
    end
    chk("R6 wide next rf", int'(wide_rf), 1);
    chk("R6 wide next if", int'(wide_if), 1);
    size_sel = 1'b0;
  endtask

  task automatic t_pwrdn();
    arm(7, 3, 1'b0);
    for (int k = 0; k < 3; k++) begin
      check_period(7, 3, k, "R7 before");
      tick();
    end
    pwr_down = 1'b1; b_val = 11'd4; a_val = 7'd1;
    tick();
    for (int k = 0; k < 10; k++) begin
      chk("R7 idle mod", int'(mod_rf) + int'(mod_if), 0);
      chk("R7 idle fb", int'(fb_rf) + int'(fb_if), 0);
      tick();
    end
    pwr_down = 1'b0;
    tick();
    run_cycles(4, 1, 2, "R7 restart");
  endtask

  task automatic t_clear();
    arm(8, 5, 1'b1);
    for (int k = 0; k < 5; k++) begin
      check_period(8, 5, k, "R8 before");
      tick();
    end
    cnt_clear = 1'b1;
    tick();
    for (int k = 0; k < 3; k++) begin
      chk("R8 idle mod", int'(mod_rf), 0);
      chk("R8 idle fb", int'(fb_rf), 0);
      tick();
    end
    cnt_clear = 1'b0;
    tick();
    run_cycles(8, 5, 1, "R8 fresh");
  endtask

  task automatic t_ifmask();
    // 0x23: 7-bit instance swallows 35, 4-bit instance swallows 3
    arm(40, 7'h23, 1'b0);
    run_cycles(40, 7'h23, 2, "R9 mask");
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    t_reset();
    t_basic();
    t_ratio(1'b0);
    t_ratio(1'b1);
    t_bounds();
    t_midchange();
    t_size();
    t_pwrdn();
    t_clear();
    t_ifmask();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule